// File: doc/BRIEF.md
# Prioritized exception vector selector

This block decides, for a small processor core, whether an exception is to be entered on the current cycle and which of seven sources wins. There are four active-low hardware request pins: a cold-start request, a critical (unmaskable) request, a fast request and a normal request. There are also three single-cycle software trap strobes. The core supplies its 8-bit status flag byte, whose bit 4 masks the normal request and whose bit 6 masks the fast request.

Except for the cold-start request, requests are only considered on cycles where the core flags an instruction boundary. The winner is reported in the same cycle with a take pulse, a 3-bit source code, a one-hot source vector and the 16-bit address of the high byte of that source's big-endian vector pair. The code and the address stay on the outputs until the next take. Fetching the vector, stacking and instruction execution belong to the core.

Top module: `exc_vector_sel`

## Requirements
- R1: While reset is asserted and right after it is released, `take_o` is 0, `src_code_o` is 6 and `vec_addr_o` is 16'hFFFE.
- R2: Source codes and vector addresses are: 0 trap1 FFFA, 1 trap2 FFF4, 2 trap3 FFF2, 3 normal FFF8, 4 fast FFF6, 5 critical FFFC, 6 cold FFFE. Bit n of `src_onehot_o` corresponds to code n, and exactly one bit is set while `take_o` is high.
- R3: Every source except cold is taken only in a cycle where `insn_bound_i` is 1. `take_o` rises in that same cycle.
- R4: A low normal pin is ignored while `status_flags_i[4]` is 1. A low fast pin is ignored while `status_flags_i[6]` is 1. With both bits set, neither pin is taken.
- R5: When several requests are eligible at once, the highest one is taken. The order from highest to lowest is cold, critical, fast, normal, trap3, trap2, trap1.
- R6: Cold is taken in the first cycle its pin is seen low, with or without a boundary. While the pin stays low, nothing further is taken and pending traps are dropped.
- R7: The critical pin is edge-triggered. A falling edge is latched, and the latch clears when the source is taken, so a pin held low is taken only once.
- R8: From reset and from any cold request until a pulse on `sp_loaded_i`, falling edges on the critical pin are ignored.
- R9: A trap strobe stays pending until its source is taken or a higher-priority source is taken. In either case it is cleared.
- R10: When no take happens, `src_code_o` and `vec_addr_o` keep the values of the last take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cold_req_n | input | 1 | Cold-start request, active low |
| crit_req_n | input | 1 | Unmaskable critical request, active low, edge-triggered |
| fast_req_n | input | 1 | Fast request, active low, masked by flag bit 6 |
| norm_req_n | input | 1 | Normal request, active low, masked by flag bit 4 |
| trap_pulse_i | input | 3 | Software trap strobes, bit 0 trap1 to bit 2 trap3 |
| status_flags_i | input | 8 | Core status flag byte |
| insn_bound_i | input | 1 | Instruction boundary marker |
| sp_loaded_i | input | 1 | Stack pointer loaded strobe, arms the critical source |
| take_o | output | 1 | Exception taken this cycle |
| src_onehot_o | output | 7 | One-hot winning source |
| src_code_o | output | 3 | Encoded winning source |
| vec_addr_o | output | 16 | Address of the vector high byte |

## Verification
The embedded assertions check on every cycle that a take carries exactly one source bit, that a masked fast or normal source is never granted, and that only cold is taken off a boundary. They also check that a critical take is never repeated in the next cycle, that a critical latch only rises while armed, and that the address holds between takes. The priority order, the exact vector addresses, trap pending and clearing, and the arming after a cold request all depend on a sequence of stimulus. Only the bench's directed scenarios show those.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_SRC  = 7;
  localparam int CODE_W   = 3;
  localparam int VEC_W    = 16;
  localparam int NUM_TRAP = 3;

  typedef enum logic [CODE_W-1:0] {
    SRC_TRAP1 = 3'd0,
    SRC_TRAP2 = 3'd1,
    SRC_TRAP3 = 3'd2,
    SRC_NORM  = 3'd3,
    SRC_FAST  = 3'd4,
    SRC_CRIT  = 3'd5,
    SRC_COLD  = 3'd6
  } src_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [CODE_W-1:0] code);
    logic [VEC_W-1:0] v;
    case (code)
      SRC_TRAP1: v = 16'hFFFA;
      SRC_TRAP2: v = 16'hFFF4;
      SRC_TRAP3: v = 16'hFFF2;
      SRC_NORM:  v = 16'hFFF8;
      SRC_FAST:  v = 16'hFFF6;
      SRC_CRIT:  v = 16'hFFFC;
      default:   v = 16'hFFFE;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/exc_trap_pend.sv
module exc_trap_pend #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drop_all,
  input  logic [N-1:0] pulse_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar g = 0; g < N; g++) begin : g_trap
    always_comb begin
      pend_d[g] = (pend_q[g] | pulse_i[g]) & ~clr_i[g] & ~drop_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end

    assign req_o[g] = pend_q[g] | pulse_i[g];

    // R9
    pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] || drop_all) |=> !pend_q[g]);
  end
endmodule

// File: rtl/exc_crit_edge.sv
module exc_crit_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic crit_n,
  input  logic cold_active,
  input  logic sp_loaded,
  input  logic taken,
  output logic latch_o
);
  logic armed_q, armed_d;
  logic prev_q;
  logic latch_q, latch_d;
  logic fall;

  assign fall = prev_q & ~crit_n;

  always_comb begin
    armed_d = armed_q;
    if (cold_active)    armed_d = 1'b0;
    else if (sp_loaded) armed_d = 1'b1;
  end

  always_comb begin
    latch_d = latch_q;
    if (cold_active)           latch_d = 1'b0;
    else if (fall && armed_q)  latch_d = 1'b1;
    else if (taken)            latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      prev_q  <= crit_n;
      latch_q <= latch_d;
    end
  end

  assign latch_o = latch_q;

  // R8
  crit_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(armed_q));
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int N = 7,
  localparam int CW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [CW-1:0] code_o,
  output logic          any_o
);
  always_comb begin
    grant_o = '0;
    code_o  = '0;
    any_o   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        code_o  = CW'(i);
        any_o   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int FLAG_W    = 8,
  parameter int NORM_MASK = 4,
  parameter int FAST_MASK = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cold_req_n,
  input  logic                crit_req_n,
  input  logic                fast_req_n,
  input  logic                norm_req_n,
  input  logic [NUM_TRAP-1:0] trap_pulse_i,
  input  logic [FLAG_W-1:0]   status_flags_i,
  input  logic                insn_bound_i,
  input  logic                sp_loaded_i,
  output logic                take_o,
  output logic [NUM_SRC-1:0]  src_onehot_o,
  output logic [CODE_W-1:0]   src_code_o,
  output logic [VEC_W-1:0]    vec_addr_o
);
  logic                cold_prev_q;
  logic                cold_active;
  logic                cold_fall;
  logic                crit_latch;
  logic [NUM_TRAP-1:0] trap_req;
  logic [NUM_TRAP-1:0] trap_clr;
  logic [NUM_SRC-1:0]  req;
  logic [NUM_SRC-1:0]  grant;
  logic [CODE_W-1:0]   win_code;
  logic                take;
  logic                bound_ok;
  logic [CODE_W-1:0]   held_q, held_d;

  assign cold_active = ~cold_req_n;
  assign cold_fall   = cold_prev_q & ~cold_req_n;
  assign bound_ok    = insn_bound_i & ~cold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cold_prev_q <= 1'b1;
    else        cold_prev_q <= cold_req_n;
  end

  exc_crit_edge u_crit (
    .clk        (clk),
    .rst_n      (rst_n),
    .crit_n     (crit_req_n),
    .cold_active(cold_active),
    .sp_loaded  (sp_loaded_i),
    .taken      (take && (win_code == SRC_CRIT)),
    .latch_o    (crit_latch)
  );

  exc_trap_pend #(.N(NUM_TRAP)) u_trap (
    .clk     (clk),
    .rst_n   (rst_n),
    .drop_all(cold_active),
    .pulse_i (trap_pulse_i),
    .clr_i   (trap_clr),
    .req_o   (trap_req)
  );

  always_comb begin
    req = '0;
    req[SRC_COLD] = cold_fall;
    req[SRC_CRIT] = bound_ok & crit_latch;
    req[SRC_FAST] = bound_ok & ~fast_req_n & ~status_flags_i[FAST_MASK];
    req[SRC_NORM] = bound_ok & ~norm_req_n & ~status_flags_i[NORM_MASK];
    for (int i = 0; i < NUM_TRAP; i++) begin
      req[int'(SRC_TRAP1) + i] = bound_ok & trap_req[i];
    end
  end

  exc_prio_arb #(.N(NUM_SRC)) u_arb (
    .req_i  (req),
    .grant_o(grant),
    .code_o (win_code),
    .any_o  (take)
  );

  always_comb begin
    for (int i = 0; i < NUM_TRAP; i++) begin
      trap_clr[i] = take && (int'(win_code) >= int'(SRC_TRAP1) + i);
    end
  end

  always_comb begin
    held_d = held_q;
    if (take) held_d = win_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= SRC_COLD;
    else        held_q <= held_d;
  end

  assign take_o       = take;
  assign src_code_o   = take ? win_code : held_q;
  assign src_onehot_o = take ? grant : NUM_SRC'(1) << held_q;
  assign vec_addr_o   = vec_of(src_code_o);

  // R2
  onehot_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($countones(src_onehot_o) == 1));
  // R4
  mask_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_code_o == SRC_FAST) |-> !status_flags_i[FAST_MASK]);
  // R4
  mask_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_code_o == SRC_NORM) |-> !status_flags_i[NORM_MASK]);
  // R3
  bound_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !insn_bound_i) |-> (src_code_o == SRC_COLD));
  // R7
  crit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_code_o == SRC_CRIT) |=> !(take_o && src_code_o == SRC_CRIT));
  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> $stable(vec_addr_o));
endmodule

// File: tb/exc_vector_sel_bench.sv
module exc_vector_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cold_n, crit_n, fast_n, norm_n;
  logic [2:0]  trap;
  logic [7:0]  flags;
  logic        bound, sp;
  logic        take;
  logic [6:0]  onehot;
  logic [2:0]  code;
  logic [15:0] vec;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_vector_sel u_exc_vector_sel (
    .clk(clk), .rst_n(rst_n), .cold_req_n(cold_n), .crit_req_n(crit_n),
    .fast_req_n(fast_n), .norm_req_n(norm_n), .trap_pulse_i(trap),
    .status_flags_i(flags), .insn_bound_i(bound), .sp_loaded_i(sp),
    .take_o(take), .src_onehot_o(onehot), .src_code_o(code), .vec_addr_o(vec)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_take(string tag, bit t, logic [2:0] c, logic [15:0] v);
    #1;
    chk({tag, " take"}, 32'(take), 32'(t));
    if (t) begin
      chk({tag, " code"}, 32'(code), 32'(c));
      chk({tag, " vec"}, 32'(vec), 32'(v));
      chk({tag, " onehot"}, 32'(onehot), 32'(7'(1) << c));
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bound = 0; trap = 0; sp = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; cold_n = 1; crit_n = 1; fast_n = 1; norm_n = 1;
    trap = 0; flags = 0; bound = 0; sp = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 take in reset", 32'(take), 0);
    chk("R1 vec in reset", 32'(vec), 32'hFFFE);
    rst_n = 1;
    #1;
    chk("R1 code", 32'(code), 6);
    chk("R1 vec", 32'(vec), 32'hFFFE);
    chk("R1 take", 32'(take), 0);
    tick();
  endtask

  task automatic t_norm();
    norm_n = 0;
    expect_take("R3 no boundary", 0, 0, 0);
    tick(); bound = 1;
    expect_take("R3 R2 normal", 1, 3, 16'hFFF8);
    tick(); norm_n = 1;
    expect_take("R10 idle", 0, 0, 0);
    chk("R10 vec hold", 32'(vec), 32'hFFF8);
    chk("R10 code hold", 32'(code), 3);
    tick();
  endtask

  task automatic t_mask();
    flags = 8'h10; norm_n = 0; bound = 1;
    expect_take("R4 normal masked", 0, 0, 0);
    tick(); flags = 8'h40; norm_n = 1; fast_n = 0; bound = 1;
    expect_take("R4 fast masked", 0, 0, 0);
    tick(); flags = 8'h50; norm_n = 0; fast_n = 0; bound = 1;
    expect_take("R4 both masked", 0, 0, 0);
    tick(); flags = 8'h40; bound = 1;
    expect_take("R4 fast masked normal wins", 1, 3, 16'hFFF8);
    tick(); flags = 8'h10; bound = 1;
    expect_take("R4 R2 fast", 1, 4, 16'hFFF6);
    tick(); flags = 8'h00; bound = 1;
    expect_take("R5 fast over normal", 1, 4, 16'hFFF6);
    tick(); fast_n = 1; norm_n = 1;
    tick();
  endtask

  task automatic t_trap();
    trap = 3'b001;
    expect_take("R9 trap1 no boundary", 0, 0, 0);
    tick();
    expect_take("R9 trap1 pending idle", 0, 0, 0);
    tick(); bound = 1;
    expect_take("R9 R2 trap1", 1, 0, 16'hFFFA);
    tick(); bound = 1;
    expect_take("R9 trap1 served", 0, 0, 0);
    tick(); trap = 3'b010; bound = 1;
    expect_take("R2 trap2", 1, 1, 16'hFFF4);
    tick(); trap = 3'b100; bound = 1;
    expect_take("R2 trap3", 1, 2, 16'hFFF2);
    tick(); trap = 3'b101;
    tick(); bound = 1;
    expect_take("R5 trap3 over trap1", 1, 2, 16'hFFF2);
    tick(); bound = 1;
    expect_take("R9 trap1 dropped by trap3", 0, 0, 0);
    tick(); trap = 3'b010;
    tick(); norm_n = 0; bound = 1;
    expect_take("R5 normal over trap2", 1, 3, 16'hFFF8);
    tick(); norm_n = 1; bound = 1;
    expect_take("R9 trap2 dropped by normal", 0, 0, 0);
    tick();
  endtask

  task automatic t_crit();
    crit_n = 0;
    tick(); bound = 1;
    expect_take("R8 disarmed", 0, 0, 0);
    tick(); crit_n = 1;
    tick(); sp = 1;
    tick(); crit_n = 0;
    expect_take("R3 crit no boundary", 0, 0, 0);
    tick(); bound = 1; fast_n = 0;
    expect_take("R5 R2 crit over fast", 1, 5, 16'hFFFC);
    tick(); bound = 1;
    expect_take("R7 held low once", 1, 4, 16'hFFF6);
    tick(); fast_n = 1; bound = 1;
    expect_take("R7 no retake", 0, 0, 0);
    tick(); crit_n = 1;
    tick();
  endtask

  task automatic t_cold();
    trap = 3'b001;
    tick(); cold_n = 0;
    expect_take("R6 R2 cold", 1, 6, 16'hFFFE);
    tick(); bound = 1; norm_n = 0;
    expect_take("R6 cold held", 0, 0, 0);
    tick(); cold_n = 1; norm_n = 1;
    tick(); bound = 1;
    expect_take("R6 trap dropped by cold", 0, 0, 0);
    tick(); crit_n = 0;
    tick(); bound = 1;
    expect_take("R8 disarmed after cold", 0, 0, 0);
    tick(); crit_n = 1;
    tick();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_norm();
    t_mask();
    t_trap();
    t_crit();
    t_cold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule